// File: doc/BRIEF.md
# Nine-Bit Word Packer

This block feeds a serial display link on which every byte travels as a nine-bit word: one data/command flag followed by the eight data bits. The shifter that drives the link handles only eight-bit words, so the packer turns the stream of flagged bytes into a plain byte stream. Each group of eight nine-bit words becomes exactly nine output bytes. The bits go out most significant bit first and run straight across byte boundaries.

A transfer is a run of input beats that ends with a beat marked last. A single beat whose flag reads command, arriving while no transfer is open, is a complete command transfer. It leaves as one nine-byte block: seven all-zero no-op words, then the command word. A data transfer of any length is packed in blocks of nine bytes. A final block that is not full is completed with zero no-op words. An optional swap mode exchanges each pair of data bytes, so that 16-bit pixels stored low byte first go out high byte first.

Top module: `nine_bit_packer`

## Requirements
- R1: After reset, `out_valid_o` is low. `in_ready_o` is high while no beat is pending and the input carries no swap-held data.
- R2: Each data byte becomes the word {1, b7..b0}. The words are concatenated MSB first, and every eight words fill exactly nine output bytes. Eight 0x00 data bytes therefore give 80 40 20 10 08 04 02 01 00.
- R3: A beat with `in_dc_i`=0 that arrives while no transfer is open is a whole command transfer. It produces eight 0x00 bytes, then the command byte, with `out_last_o` on the ninth byte. The value of `in_last_i` has no effect on such a beat.
- R4: If a data transfer ends in the middle of a block, the block is completed with zero words, so the output is still nine bytes. One data byte 0xA5 gives D2 80 followed by seven 0x00 bytes.
- R5: A data transfer of n bytes produces 9*ceil(n/8) bytes, with no gaps between its blocks.
- R6: With `swap_i`=1, the data bytes of a transfer are taken in pairs counted from its first beat, and each pair is sent second byte first. A trailing unpaired byte is sent unchanged. `swap_i` must stay constant during a transfer.
- R7: After the first beat of a data transfer, `in_dc_i` is ignored. Every later beat is packed with flag 1.
- R8: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o`, `out_byte_o` and `out_last_o` hold their values. No byte is lost or duplicated.
- R9: `out_last_o` is high only on the final byte of a transfer, and every transfer's byte count is a multiple of nine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| swap_i | input | 1 | Swap data bytes pairwise for the current transfer |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat accepted when high with valid |
| in_byte_i | input | 8 | Input byte |
| in_dc_i | input | 1 | 1 = data, 0 = command (sampled on a transfer's first beat) |
| in_last_i | input | 1 | Last beat of a data transfer |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Downstream takes the output byte |
| out_byte_o | output | 8 | Packed output byte |
| out_last_o | output | 1 | Final byte of a transfer |

## Verification
A wrong word-position count or a corrupt carry shows up at once. The next output byte has its flag bit in the wrong place or carries leftover bits. The following `out_last_o` then lands on a byte count that is not a multiple of nine. A lost swap-hold or transfer-open state appears within one or two bytes, as exchanged or unexchanged pairs, or as a mid-transfer byte treated as a command. Each transfer is compared byte for byte with an independently computed bit stream, and under random backpressure.

// File: rtl/nbp_pkg.sv
package nbp_pkg;
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = BYTE_W + 1;
  localparam int BLK_WORDS = BYTE_W;       // words per block
  localparam int BLK_BYTES = WORD_W;       // bytes per block
  localparam int PEND_W    = $clog2(BLK_WORDS + 1);
  localparam int REM_W     = $clog2(BLK_BYTES + 1);
  localparam int ACC_W     = 2 * BYTE_W;

  typedef enum logic [1:0] {ORD_PASS, ORD_HOLD, ORD_PEND} ord_st_e;
  typedef enum logic {PK_RUN, PK_EMIT} pk_st_e;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              cmd;
    logic              last;
  } beat_t;
endpackage

// File: rtl/nbp_order.sv
// Classifies beats (command vs data) and applies pairwise byte swap.
module nbp_order
  import nbp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              swap_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [BYTE_W-1:0] in_byte_i,
  input  logic              in_dc_i,
  input  logic              in_last_i,
  output logic              w_valid_o,
  input  logic              w_ready_i,
  output beat_t             w_beat_o
);

  ord_st_e           st_q, st_d;
  logic              open_q, open_d;
  logic [BYTE_W-1:0] held_q;
  logic              held_last_q;
  logic              beat_cmd, hold_first;
  logic              take_first, take_second;

  assign beat_cmd   = !open_q && !in_dc_i;
  assign hold_first = !beat_cmd && swap_i && !in_last_i;

  always_comb begin
    st_d        = st_q;
    open_d      = open_q;
    in_ready_o  = 1'b0;
    w_valid_o   = 1'b0;
    take_first  = 1'b0;
    take_second = 1'b0;
    w_beat_o    = '{data: in_byte_i, cmd: beat_cmd, last: in_last_i | beat_cmd};
    unique case (st_q)
      ORD_PASS: begin
        if (hold_first) begin
          in_ready_o = 1'b1;
          if (in_valid_i) begin
            take_first = 1'b1;
            st_d       = ORD_HOLD;
            open_d     = 1'b1;
          end
        end else begin
          in_ready_o = w_ready_i;
          w_valid_o  = in_valid_i;
          if (in_valid_i && w_ready_i) open_d = !(in_last_i || beat_cmd);
        end
      end
      ORD_HOLD: begin
        in_ready_o    = w_ready_i;
        w_valid_o     = in_valid_i;
        w_beat_o.cmd  = 1'b0;
        w_beat_o.last = 1'b0;
        if (in_valid_i && w_ready_i) begin
          take_second = 1'b1;
          st_d        = ORD_PEND;
          open_d      = !in_last_i;
        end
      end
      ORD_PEND: begin
        w_valid_o = 1'b1;
        w_beat_o  = '{data: held_q, cmd: 1'b0, last: held_last_q};
        if (w_ready_i) st_d = ORD_PASS;
      end
      default: st_d = ORD_PASS;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ORD_PASS;
      open_q      <= 1'b0;
      held_q      <= '0;
      held_last_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      open_q <= open_d;
      if (take_first)  held_q      <= in_byte_i;
      if (take_second) held_last_q <= in_last_i;
    end
  end

endmodule

// File: rtl/nbp_pack.sv
// Packs tagged words into 9-byte blocks, pads commands and data tails.
module nbp_pack
  import nbp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              w_valid_i,
  output logic              w_ready_o,
  input  beat_t             w_beat_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [BYTE_W-1:0] out_byte_o,
  output logic              out_last_o
);

  pk_st_e            st_q, st_d;
  logic [PEND_W-1:0] pend_q, pend_d, np;
  logic [BYTE_W-1:0] carry_q, carry_d, final_q, final_d;
  logic [REM_W-1:0]  rem_q, rem_d;
  logic              end_q, end_d;
  logic [ACC_W-1:0]  cat;
  logic [BYTE_W-1:0] cat_byte, ncarry;
  logic              slot_free, push, push_last;
  logic [BYTE_W-1:0] push_byte;
  logic              ov_q, ol_q;
  logic [BYTE_W-1:0] ob_q;

  assign slot_free = !ov_q || out_ready_i;
  assign np        = pend_q + PEND_W'(1);

  // pending bits sit left-aligned in carry; the new word lands right below them
  always_comb begin
    cat      = {carry_q, {BYTE_W{1'b0}}}
             | (ACC_W'({1'b1, w_beat_i.data}) << (BYTE_W - 1 - int'(pend_q)));
    cat_byte = cat[ACC_W-1 -: BYTE_W];
    ncarry   = cat[BYTE_W-1:0];
  end

  always_comb begin
    st_d      = st_q;
    pend_d    = pend_q;
    carry_d   = carry_q;
    rem_d     = rem_q;
    final_d   = final_q;
    end_d     = end_q;
    push      = 1'b0;
    push_byte = '0;
    push_last = 1'b0;
    w_ready_o = (st_q == PK_RUN) && slot_free;
    if (st_q == PK_RUN) begin
      if (w_valid_i && slot_free) begin
        push = 1'b1;
        if (w_beat_i.cmd) begin
          push_byte = '0;
          st_d      = PK_EMIT;
          rem_d     = REM_W'(BLK_BYTES - 1);
          carry_d   = '0;
          final_d   = w_beat_i.data;
          end_d     = 1'b1;
          pend_d    = '0;
        end else begin
          push_byte = cat_byte;
          if (np == PEND_W'(BLK_WORDS)) begin
            st_d    = PK_EMIT;
            rem_d   = REM_W'(1);
            final_d = ncarry;
            carry_d = '0;
            end_d   = w_beat_i.last;
            pend_d  = '0;
          end else if (w_beat_i.last) begin
            st_d    = PK_EMIT;
            rem_d   = REM_W'(BLK_BYTES) - REM_W'(np);
            final_d = '0;
            carry_d = ncarry;
            end_d   = 1'b1;
            pend_d  = '0;
          end else begin
            carry_d = ncarry;
            pend_d  = np;
          end
        end
      end
    end else if (slot_free) begin
      push      = 1'b1;
      push_byte = (rem_q == REM_W'(1)) ? final_q : carry_q;
      push_last = (rem_q == REM_W'(1)) && end_q;
      carry_d   = '0;
      rem_d     = rem_q - REM_W'(1);
      if (rem_q == REM_W'(1)) st_d = PK_RUN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= PK_RUN;
      pend_q  <= '0;
      carry_q <= '0;
      rem_q   <= '0;
      final_q <= '0;
      end_q   <= 1'b0;
      ov_q    <= 1'b0;
      ob_q    <= '0;
      ol_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      pend_q  <= pend_d;
      carry_q <= carry_d;
      rem_q   <= rem_d;
      final_q <= final_d;
      end_q   <= end_d;
      if (push) begin
        ov_q <= 1'b1;
        ob_q <= push_byte;
        ol_q <= push_last;
      end else if (out_ready_i) begin
        ov_q <= 1'b0;
      end
    end
  end

  assign out_valid_o = ov_q;
  assign out_byte_o  = ob_q;
  assign out_last_o  = ol_q;

endmodule

// File: rtl/nine_bit_packer.sv
module nine_bit_packer
  import nbp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              swap_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [BYTE_W-1:0] in_byte_i,
  input  logic              in_dc_i,
  input  logic              in_last_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [BYTE_W-1:0] out_byte_o,
  output logic              out_last_o
);

  logic  w_valid, w_ready;
  beat_t w_beat;

  nbp_order u_order (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .swap_i     (swap_i),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .in_byte_i  (in_byte_i),
    .in_dc_i    (in_dc_i),
    .in_last_i  (in_last_i),
    .w_valid_o  (w_valid),
    .w_ready_i  (w_ready),
    .w_beat_o   (w_beat)
  );

  nbp_pack u_pack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .w_valid_i   (w_valid),
    .w_ready_o   (w_ready),
    .w_beat_i    (w_beat),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_byte_o  (out_byte_o),
    .out_last_o  (out_last_o)
  );

endmodule

// File: rtl/nine_bit_packer_chk.sv
module nine_bit_packer_chk
  import nbp_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              out_valid_i,
  input logic              out_ready_i,
  input logic [BYTE_W-1:0] out_byte_i,
  input logic              out_last_i,
  input logic              w_valid_i,
  input logic              w_ready_i,
  input logic              w_cmd_i
);

  logic [REM_W-1:0] idx_q;
  logic             cmd_blk_q;
  logic             out_fire, cmd_fire;

  assign out_fire = out_valid_i && out_ready_i;
  assign cmd_fire = w_valid_i && w_ready_i && w_cmd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q     <= '0;
      cmd_blk_q <= 1'b0;
    end else begin
      if (out_fire) idx_q <= (idx_q == REM_W'(BLK_BYTES - 1)) ? '0 : idx_q + REM_W'(1);
      if (cmd_fire) cmd_blk_q <= 1'b1;
      else if (out_fire && out_last_i) cmd_blk_q <= 1'b0;
    end
  end

  // R8
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i && !out_ready_i |=> out_valid_i && $stable(out_byte_i) && $stable(out_last_i));

  // R9
  last_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_fire && out_last_i |-> idx_q == REM_W'(BLK_BYTES - 1));

  // R3
  cmd_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_fire && cmd_blk_q && idx_q != REM_W'(BLK_BYTES - 1) |-> out_byte_i == '0);

  // R3
  cmd_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_fire |-> !out_valid_i || out_last_i);

  // R2
  data_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_fire && !cmd_blk_q && idx_q == '0 |-> out_byte_i[BYTE_W-1]);

endmodule

bind nine_bit_packer nine_bit_packer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .out_valid_i (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_byte_i  (out_byte_o),
  .out_last_i  (out_last_o),
  .w_valid_i   (w_valid),
  .w_ready_i   (w_ready),
  .w_cmd_i     (w_beat.cmd)
);

// File: tb/nine_bit_packer_tb.sv
`timescale 1ns/1ps
module nine_bit_packer_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       swap_i = 1'b0;
  logic       in_valid_i = 1'b0;
  logic       in_ready_o;
  logic [7:0] in_byte_i = '0;
  logic       in_dc_i = 1'b1;
  logic       in_last_i = 1'b0;
  logic       out_valid_o;
  logic       out_ready_i = 1'b1;
  logic [7:0] out_byte_o;
  logic       out_last_o;

  always #10 clk = ~clk;

  nine_bit_packer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .swap_i(swap_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_byte_i(in_byte_i),
    .in_dc_i(in_dc_i), .in_last_i(in_last_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_byte_o(out_byte_o), .out_last_o(out_last_o)
  );

  int checks = 0;
  int errors = 0;
  int stall_seen = 0;
  int stall_bad = 0;
  bit rdy_rand = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [7:0] src_q[$];
  logic [8:0] exp_q[$];
  logic [8:0] got_q[$];

  // cmd[23] swap[22] len[21:16] seed[15:8] step[7:0]
  localparam int N_VEC = 10;
  localparam logic [23:0] VEC [N_VEC] = '{
    {1'b0, 1'b0, 6'd8,  8'h12, 8'h35},
    {1'b1, 1'b0, 6'd1,  8'h2C, 8'h00},
    {1'b0, 1'b0, 6'd3,  8'hA5, 8'h5A},
    {1'b0, 1'b1, 6'd16, 8'h01, 8'h13},
    {1'b0, 1'b0, 6'd20, 8'hF0, 8'h07},
    {1'b0, 1'b1, 6'd5,  8'h80, 8'h21},
    {1'b1, 1'b0, 6'd1,  8'h2A, 8'h00},
    {1'b0, 1'b0, 6'd1,  8'hFF, 8'h00},
    {1'b0, 1'b1, 6'd2,  8'h34, 8'h22},
    {1'b0, 1'b0, 6'd7,  8'h3C, 8'h11}
  };

  localparam logic [7:0] HAND_ZERO [9] = '{8'h80, 8'h40, 8'h20, 8'h10, 8'h08, 8'h04, 8'h02, 8'h01, 8'h00};
  localparam logic [7:0] HAND_A5   [9] = '{8'hD2, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
  localparam logic [7:0] HAND_CMD  [9] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h2C};

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: got %0d expected 0 pending", 1);
    summary();
    $finish;
  end

  // downstream ready
  initial forever begin
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready_i = rdy_rand ? lfsr[0] : 1'b1;
  end

  // output monitor, samples 2 ns before the rising edge
  initial begin
    bit         prev_stall = 1'b0;
    logic [8:0] prev_val = '0;
    forever begin
      @(negedge clk);
      #8;
      if (rst_n) begin
        if (prev_stall) begin
          if (!out_valid_o || {out_last_o, out_byte_o} != prev_val) stall_bad++;
        end
        if (out_valid_o && out_ready_i) got_q.push_back({out_last_o, out_byte_o});
        prev_stall = out_valid_o && !out_ready_i;
        if (prev_stall) stall_seen++;
        prev_val = {out_last_o, out_byte_o};
      end else begin
        prev_stall = 1'b0;
      end
    end
  end

  task automatic build_exp(input bit is_cmd, input bit sw);
    bit         bits[$];
    logic [7:0] ord[$];
    int         n = src_q.size();
    int         i = 0;
    int         nb;
    if (is_cmd) begin
      for (int k = 0; k < 64; k++) bits.push_back(1'b0);
      for (int b = 7; b >= 0; b--) bits.push_back(src_q[0][b]);
    end else begin
      while (i < n) begin
        if (sw && i + 1 < n) begin
          ord.push_back(src_q[i+1]);
          ord.push_back(src_q[i]);
          i += 2;
        end else begin
          ord.push_back(src_q[i]);
          i++;
        end
      end
      foreach (ord[k]) begin
        bits.push_back(1'b1);
        for (int b = 7; b >= 0; b--) bits.push_back(ord[k][b]);
      end
      while (bits.size() % 72 != 0) bits.push_back(1'b0);
    end
    nb = bits.size() / 8;
    for (int j = 0; j < nb; j++) begin
      logic [7:0] v;
      for (int b = 0; b < 8; b++) v[7-b] = bits[j*8+b];
      exp_q.push_back({(j == nb - 1), v});
    end
  endtask

  task automatic send(input bit is_cmd, input bit sw, input bit dc_mid);
    int n = src_q.size();
    @(negedge clk);
    swap_i = sw;
    for (int i = 0; i < n; i++) begin
      bit acc = 1'b0;
      in_valid_i = 1'b1;
      in_byte_i  = src_q[i];
      in_dc_i    = (i == 0) ? !is_cmd : dc_mid;
      in_last_i  = (i == n - 1);
      while (!acc) begin
        #8;
        acc = in_ready_o;
        @(negedge clk);
      end
    end
    in_valid_i = 1'b0;
    in_last_i  = 1'b0;
    in_dc_i    = 1'b1;
  endtask

  task automatic run_xfer(input bit is_cmd, input bit sw, input bit dc_mid, input string tag);
    int guard = 0;
    int bad = -1;
    exp_q.delete();
    got_q.delete();
    build_exp(is_cmd, sw);
    send(is_cmd, sw, dc_mid);
    while (got_q.size() < exp_q.size() && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    repeat (12) @(negedge clk);
    checks++;
    if (got_q.size() != exp_q.size()) begin
      errors++;
      $display("FAIL %s byte count got %0d expected %0d", tag, got_q.size(), exp_q.size());
    end else begin
      foreach (exp_q[k]) if (bad < 0 && got_q[k] != exp_q[k]) bad = k;
      if (bad >= 0) begin
        errors++;
        $display("FAIL %s byte %0d got %h expected %h", tag, bad, got_q[bad], exp_q[bad]);
      end
    end
    // R9: whole blocks only
    checks++;
    if (got_q.size() % 9 != 0 || got_q.size() == 0) begin
      errors++;
      $display("FAIL R9 (%s) byte count got %0d expected multiple of 9", tag, got_q.size());
    end
  endtask

  task automatic hand_cmp(input logic [7:0] ref_b [9], input string tag);
    int bad = -1;
    checks++;
    if (got_q.size() != 9) bad = 99;
    else for (int k = 0; k < 9; k++) if (bad < 0 && got_q[k][7:0] != ref_b[k]) bad = k;
    if (bad >= 0) begin
      errors++;
      if (bad == 99) $display("FAIL %s hand count got %0d expected 9", tag, got_q.size());
      else $display("FAIL %s hand byte %0d got %h expected %h", tag, bad, got_q[bad][7:0], ref_b[bad]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #8;
    // R1
    checks++;
    if (out_valid_o !== 1'b0 || in_ready_o !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset state got valid=%b ready=%b expected valid=0 ready=1", out_valid_o, in_ready_o);
    end

    // R2 hand vector: eight zero data bytes
    src_q.delete();
    for (int i = 0; i < 8; i++) src_q.push_back(8'h00);
    run_xfer(1'b0, 1'b0, 1'b1, "R2");
    hand_cmp(HAND_ZERO, "R2");

    // R3 hand vector: command 0x2C
    src_q.delete();
    src_q.push_back(8'h2C);
    run_xfer(1'b1, 1'b0, 1'b1, "R3");
    hand_cmp(HAND_CMD, "R3");

    // R4 hand vector: single data byte padded
    src_q.delete();
    src_q.push_back(8'hA5);
    run_xfer(1'b0, 1'b0, 1'b1, "R4");
    hand_cmp(HAND_A5, "R4");

    // table, pass 0 free-running output, pass 1 random backpressure (R8)
    for (int p = 0; p < 2; p++) begin
      rdy_rand = (p == 1);
      for (int v = 0; v < N_VEC; v++) begin
        logic  is_cmd = VEC[v][23];
        logic  sw     = VEC[v][22];
        int    len    = int'(VEC[v][21:16]);
        string tag;
        src_q.delete();
        for (int i = 0; i < len; i++) src_q.push_back(8'(VEC[v][15:8] + i * VEC[v][7:0]));
        if (is_cmd)      tag = "R3";
        else if (sw)     tag = "R6";
        else if (len > 8) tag = "R5";
        else if (len < 8) tag = "R4";
        else             tag = "R2";
        run_xfer(is_cmd, sw, 1'b1, tag);
      end
    end

    // R7: command flag on later beats is ignored
    rdy_rand = 1'b1;
    src_q.delete();
    for (int i = 0; i < 11; i++) src_q.push_back(8'(8'h5C + i * 3));
    run_xfer(1'b0, 1'b0, 1'b0, "R7");
    // R7 with swap and stalls
    run_xfer(1'b0, 1'b1, 1'b0, "R7");
    rdy_rand = 1'b0;

    // R3: last flag ignored on a command beat, followed by data
    src_q.delete();
    src_q.push_back(8'h29);
    run_xfer(1'b1, 1'b0, 1'b1, "R3");
    src_q.delete();
    for (int i = 0; i < 9; i++) src_q.push_back(8'(8'hC3 ^ i));
    run_xfer(1'b0, 1'b0, 1'b1, "R5");

    // R8
    checks++;
    if (stall_bad != 0 || stall_seen == 0) begin
      errors++;
      $display("FAIL R8 stall violations got %0d expected 0 (stalls seen %0d)", stall_bad, stall_seen);
    end

    summary();
    $finish;
  end

endmodule